// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the output latch of an 8-bit general-purpose port and turns each latch bit into three pad controls: a strong pulldown, a momentary strong pullup and a weak pullup. A pin whose latch holds 1 is driven only weakly high, so outside logic can pull it low and the pin works as an input. A pin whose latch holds 0 is held low by the strong pulldown. When a pin goes from 0 to 1, a strong pullup fires for a short fixed pulse so the rising edge is fast. After the pulse the pin falls back to the weak pullup.

Software writes the latch with a one-cycle write strobe. Every write is taken in the cycle it is presented, so the write path has no back-pressure. Reads return the pad levels after a two-flop synchronizer, not the latch contents. A per-pin alternate-function select lets a peripheral output drive the pad logic in place of the latch bit. While the select is set, the latch still records software writes.

Top module: `qbp_port`

## Requirements
- R1: After reset every latch bit is 1. On every pin only the weak pullup is enabled: `pull_dn_en`=0x00, `boost_en`=0x00, `weak_up_en`=0xFF. With all pads high, `rd_data` reads 0xFF.
- R2: A write with bit i = 0 enables `pull_dn_en[i]` from the cycle after the write edge, with both pullups off. The pulldown stays on until a 1 is written to that bit or reset occurs.
- R3: A write that changes bit i from 0 to 1 raises `boost_en[i]` for exactly BOOST_CYC cycles (2 by default), starting in the cycle after the write edge. `weak_up_en[i]` stays low during the pulse and is high afterwards.
- R4: Writing 1 to a bit that already holds 1 fires no strong pullup; `weak_up_en[i]` stays high.
- R5: `pull_dn_en[i]` and `boost_en[i]` are never high in the same cycle.
- R6: A pad level applied before clock edge k appears on `rd_data` after edge k+1 and not after edge k. The read value is independent of the latch.
- R7: While `alt_sel[i]`=1, `alt_out[i]` replaces latch bit i in the driver logic, and software writes have no effect on that pin's controls. A 0-to-1 change of the effective value fires the boost, whichever source causes it.
- R8: Writing 0 to a pin while its boost pulse is running ends the pulse at once and turns the pulldown on.
- R9: Bit i of `wr_data` controls pin i only. Pins are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe, taken every cycle it is high |
| wr_data | input | 8 | New latch value |
| alt_sel | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Peripheral output values used when selected |
| pad_in | input | 8 | Raw pad levels |
| pull_dn_en | output | 8 | Strong pulldown enable per pin |
| boost_en | output | 8 | Momentary strong pullup enable per pin |
| weak_up_en | output | 8 | Weak sustaining pullup enable per pin |
| rd_data | output | 8 | Synchronized pad levels |

## Verification
The bench writes each of the 256 latch values followed by its complement, so every pin sees 0-to-1, 1-to-0, 1-to-1 and 0-to-0 steps. At each step it checks the pulse's start cycle, its length and the return to the weak pullup. A design that boosts on a rewritten 1 would show spurious `boost_en` bits. A pulse one cycle too short or too long shows up in the second or third sample. A write of 0 in the middle of a pulse checks that the boost is cut off rather than fighting the new pulldown. The pad sweep samples `rd_data` after one edge and after two edges, which catches a synchronizer with the wrong depth or a read path taken from the latch. The alternate-function test checks that writes are ignored while the select is set and that a boost fires when the select is dropped.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef struct packed {
    logic pd;   // strong pulldown
    logic spu;  // momentary strong pullup
    logic wpu;  // weak sustaining pullup
  } pad_ctrl_t;
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '1;
    else if (wr_en) latch_q <= wr_data;
  end

  // R9
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_q == $past(wr_data));

  // R1
  latch_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> latch_q == '1);
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  if (STAGES == 2) begin : g_lat_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               warm_q <= '0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end
    // R6
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> q == $past(d, 2));
  end
endmodule

// File: rtl/qbp_pin_drv.sv
module qbp_pin_drv
  import qbp_pkg::*;
#(
  parameter int BOOST_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      drive_val,
  output pad_ctrl_t ctrl
);
  localparam int CW = $clog2(BOOST_CYC + 1);

  logic          prev_q;
  logic [CW-1:0] left_q;
  logic          rise;

  assign rise = drive_val & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      left_q <= '0;
    end else begin
      prev_q <= drive_val;
      if (!drive_val)        left_q <= '0;
      else if (rise)         left_q <= CW'(BOOST_CYC - 1);
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  always_comb begin
    ctrl.pd  = ~drive_val;
    ctrl.spu = drive_val & (rise | (left_q != '0));
    ctrl.wpu = drive_val & ~ctrl.spu;
  end

  // consecutive boost cycles, for the pulse-length check
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (!ctrl.spu) run_q <= '0;
    else if (run_q != CW'(BOOST_CYC)) run_q <= run_q + 1'b1;
  end

  // R5
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.pd && ctrl.spu));

  // R3
  boost_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.spu |-> run_q < CW'(BOOST_CYC));

  // R3
  boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.pd) && drive_val) |-> ctrl.spu);

  // R2
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.pd) && !drive_val) |-> (ctrl.pd && !ctrl.wpu && !ctrl.spu));
endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int BOOST_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_data,
  input  logic [NPINS-1:0] alt_sel,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pull_dn_en,
  output logic [NPINS-1:0] boost_en,
  output logic [NPINS-1:0] weak_up_en,
  output logic [NPINS-1:0] rd_data
);
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] eff;

  qbp_latch #(.W(NPINS)) latch_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .latch_q(latch_q)
  );

  assign eff = (alt_sel & alt_out) | (~alt_sel & latch_q);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pad_ctrl_t c;
    qbp_pin_drv #(.BOOST_CYC(BOOST_CYC)) drv_i (
      .clk(clk), .rst_n(rst_n), .drive_val(eff[i]), .ctrl(c)
    );
    assign pull_dn_en[i] = c.pd;
    assign boost_en[i]   = c.spu;
    assign weak_up_en[i] = c.wpu;
  end

  qbp_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(rd_data)
  );

  // R7
  alt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel != '0 && $past(alt_sel) == alt_sel && $past(alt_out) == alt_out)
      |-> ((pull_dn_en & alt_sel) == $past(pull_dn_en & alt_sel)));

  // R5
  port_no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dn_en & boost_en) == '0);
endmodule

// File: tb/qbp_port_tb_top.sv
module qbp_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] alt_sel = '0;
  logic [7:0] alt_out = '0;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pull_dn_en, boost_en, weak_up_en, rd_data;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  qbp_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .alt_sel(alt_sel), .alt_out(alt_out), .pad_in(pad_in),
    .pull_dn_en(pull_dn_en), .boost_en(boost_en), .weak_up_en(weak_up_en),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [7:0] oldv, input logic [7:0] v);
    wr(v);
    chk("R2 pd first cycle", pull_dn_en, ~v);
    chk("R3 boost first cycle", boost_en, v & ~oldv);
    chk("R4 weak on kept ones", weak_up_en, v & oldv);
    @(negedge clk);
    chk("R3 boost second cycle", boost_en, v & ~oldv);
    chk("R5 no overlap", pull_dn_en & boost_en, 8'h00);
    @(negedge clk);
    chk("R3 boost ended", boost_en, 8'h00);
    chk("R3 weak after pulse", weak_up_en, v);
    chk("R2 pd held", pull_dn_en, ~v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] oldv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 pd reset", pull_dn_en, 8'h00);
    chk("R1 boost reset", boost_en, 8'h00);
    chk("R1 weak reset", weak_up_en, 8'hFF);
    chk("R1 read reset", rd_data, 8'hFF);

    // R2 R3 R4 R9 sweep
    oldv = 8'hFF;
    for (int i = 0; i < 256; i++) begin
      step(oldv, 8'(i));
      step(8'(i), ~8'(i));
      oldv = ~8'(i);
    end

    // R8 abort a running pulse
    step(oldv, 8'h00);
    wr(8'hFF);
    chk("R8 pulse started", boost_en, 8'hFF);
    wr(8'h0F);
    chk("R8 pulse cut", boost_en, 8'h0F);
    chk("R8 pd on at once", pull_dn_en, 8'hF0);
    @(negedge clk);
    chk("R8 tail weak", weak_up_en, 8'h0F);
    chk("R8 tail boost", boost_en, 8'h00);

    // R7 alternate function
    step(8'h0F, 8'h00);
    alt_sel = 8'hFF;
    alt_out = 8'hAA;
    @(negedge clk);
    chk("R7 alt pd", pull_dn_en, 8'h55);
    chk("R7 alt boost", boost_en, 8'hAA);
    @(negedge clk);
    chk("R7 alt weak", weak_up_en, 8'hAA);
    wr(8'hFF);
    chk("R7 write ignored pd", pull_dn_en, 8'h55);
    chk("R7 write ignored boost", boost_en, 8'h00);
    chk("R7 write ignored weak", weak_up_en, 8'hAA);
    alt_sel = 8'h00;
    @(negedge clk);
    chk("R7 release boost", boost_en, 8'h55);
    chk("R7 release pd", pull_dn_en, 8'h00);
    @(negedge clk);
    chk("R7 release weak", weak_up_en, 8'hFF);

    // R6 synchronizer depth, latch held at 0
    step(8'hFF, 8'h00);
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 256; p++) begin
      logic [7:0] prevp;
      prevp = pad_in;
      pad_in = 8'(p);
      @(negedge clk);
      chk("R6 one edge", rd_data, prevp);
      @(negedge clk);
      chk("R6 two edges", rd_data, 8'(p));
    end

    summary();
  end
endmodule